// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines from devices and condenses them into one interrupt signal for a processor. Each line can be gated off by a software-writable mask. Among the lines that are both requesting and unmasked, a fixed order picks the winner: line 0 wins over every other line, and line 7 loses to every other line. The block raises its interrupt output only if the winner outranks every request already being serviced.

When the processor acknowledges with an active-low strobe, the block lowers its interrupt output. It then returns an 8-bit vector, which is a programmable base plus the winning line number, on a data output with its own drive-enable. The winning line moves into the in-service set and stays there until software writes an end-of-interrupt command. Until then, requests of equal or lower rank are held off, while a request of higher rank can still nest on top.

A host reaches the block through two byte addresses. Address 0 takes commands. Address 1 holds the mask, which the host can read and write, and it also takes the vector base during initialization.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF (all lines disabled), the in-service and request sets are empty, `intr_o` is low and `vec_oe_o` is low.
- R2: A write to address 1 (outside initialization) loads the mask, and a read at address 1 returns it. A read at address 0 returns 0x00.
- R3: A write to address 0 with bit 4 set starts initialization. The next write to address 1 loads the vector base with its low three bits forced to zero. Later writes to address 1 load the mask again.
- R4: A mask bit of 1 disables its line. `intr_o` rises two clock edges after an unmasked line goes high, and it never rises for a masked line.
- R5: When several unmasked lines are pending, the vector returned is the one for the lowest line number.
- R6: If `inta_n_i` is sampled low after being high, the next cycle shows `intr_o` low and `vec_oe_o` high with `vec_o` equal to the base plus the line number. `vec_oe_o` falls on the edge after `inta_n_i` is sampled high again.
- R7: An acknowledge adds the winning line to the in-service set. While that set is not empty, `intr_o` rises only for a line whose number is lower than the lowest line in service.
- R8: Writing exactly 0x20 to address 0 removes the lowest-numbered line from the in-service set. Other command values with bit 4 clear have no effect.
- R9: Requests follow the lines: a line that drops before it is acknowledged withdraws `intr_o`. An acknowledge with no eligible request returns the base plus 7 and leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Device request lines, level-sensitive |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe |
| bus_addr_i | input | 1 | 0 = command, 1 = mask/base |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data (combinational) |
| intr_o | output | 1 | Interrupt to processor |
| inta_n_i | input | 1 | Active-low acknowledge from processor |
| vec_o | output | 8 | Vector code |
| vec_oe_o | output | 1 | Drive-enable for vec_o |

## Verification
A corrupted in-service set shows up at the ports soon after the fault. `intr_o` either stays low when a higher-ranked line is waiting, or rises again for a line of equal rank. Either symptom appears within two edges of the next change on a request line. A wrong end-of-interrupt that clears the wrong bit only shows up on the second end-of-interrupt, so the bench stacks two nested requests and checks `intr_o` after each release. A bad base or a bad priority encode shows up as a wrong vector in the single acknowledge cycle, and the scoreboard compares that vector directly.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int IRQ_N = 8;
    localparam int DATA_W = 8;
    localparam int IDX_W = $clog2(IRQ_N);
    localparam int ALIGN_W = IDX_W;
    localparam logic [DATA_W-1:0] CMD_EOI = 8'h20;
    localparam int CMD_INIT_BIT = 4;

    typedef struct packed {
        logic [IRQ_N-1:0]  irr;
        logic [IRQ_N-1:0]  imr;
        logic [IRQ_N-1:0]  isr;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] vec;
        logic              init_wait;
        logic              intr;
        logic              oe;
        logic              inta_prev;
    } state_t;
endpackage

// File: rtl/prio_intc_prienc.sv
module prio_intc_prienc
    import prio_intc_pkg::*;
(
    input  logic [IRQ_N-1:0] bits_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (bits_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc_cmd.sv
module prio_intc_cmd
    import prio_intc_pkg::*;
(
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              init_o,
    output logic              eoi_o,
    output logic              data_wr_o
);
    always_comb begin
        init_o    = wr_i && !addr_i && wdata_i[CMD_INIT_BIT];
        eoi_o     = wr_i && !addr_i && (wdata_i == CMD_EOI);
        data_wr_o = wr_i && addr_i;
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_BASE = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_N-1:0]  irq_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic              bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              intr_o,
    input  logic              inta_n_i,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_oe_o
);
    state_t st_q, st_d;

    logic init_cmd, eoi_cmd, data_wr;
    logic win_valid, top_valid;
    logic [IDX_W-1:0] win_idx, top_idx;
    logic [IRQ_N-1:0] eligible;
    logic ack_start, present;

    logic [IRQ_N-1:0]  irr_w, imr_w, isr_w;
    logic [DATA_W-1:0] base_w;

    prio_intc_cmd u_cmd (
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .init_o    (init_cmd),
        .eoi_o     (eoi_cmd),
        .data_wr_o (data_wr)
    );

    assign eligible = st_q.irr & ~st_q.imr;

    prio_intc_prienc u_req_enc (
        .bits_i  (eligible),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    prio_intc_prienc u_isr_enc (
        .bits_i  (st_q.isr),
        .valid_o (top_valid),
        .idx_o   (top_idx)
    );

    always_comb begin
        st_d      = st_q;
        ack_start = st_q.inta_prev && !inta_n_i;
        present   = win_valid && (!top_valid || (win_idx < top_idx));

        st_d.irr       = irq_i;
        st_d.inta_prev = inta_n_i;

        if (ack_start) begin
            st_d.oe = 1'b1;
            if (win_valid) begin
                st_d.vec = st_q.base + DATA_W'(win_idx);
                st_d.isr[win_idx] = 1'b1;
            end else begin
                st_d.vec = st_q.base + DATA_W'(IRQ_N - 1);
            end
        end else if (inta_n_i) begin
            st_d.oe = 1'b0;
        end

        if (eoi_cmd && top_valid) begin
            st_d.isr[top_idx] = 1'b0;
        end

        if (init_cmd) begin
            st_d.init_wait = 1'b1;
        end else if (data_wr) begin
            if (st_q.init_wait) begin
                st_d.base      = {bus_wdata_i[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                st_d.init_wait = 1'b0;
            end else begin
                st_d.imr = bus_wdata_i;
            end
        end

        st_d.intr = present && !ack_start && inta_n_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.irr       <= '0;
            st_q.imr       <= '1;
            st_q.isr       <= '0;
            st_q.base      <= RESET_BASE & ~DATA_W'((1 << ALIGN_W) - 1);
            st_q.vec       <= '0;
            st_q.init_wait <= 1'b0;
            st_q.intr      <= 1'b0;
            st_q.oe        <= 1'b0;
            st_q.inta_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = (bus_rd_i && bus_addr_i) ? st_q.imr : '0;
    assign intr_o      = st_q.intr;
    assign vec_o       = st_q.vec;
    assign vec_oe_o    = st_q.oe;

    assign irr_w  = st_q.irr;
    assign imr_w  = st_q.imr;
    assign isr_w  = st_q.isr;
    assign base_w = st_q.base;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              intr_o,
    input logic              inta_n_i,
    input logic              vec_oe_o,
    input logic              bus_wr_i,
    input logic              bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [IRQ_N-1:0]  irr,
    input logic [IRQ_N-1:0]  imr,
    input logic [IRQ_N-1:0]  isr,
    input logic [DATA_W-1:0] base
);
    logic eoi_wr;
    assign eoi_wr = bus_wr_i && !bus_addr_i && (bus_wdata_i == CMD_EOI);

    a_r4_intr_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_o) |-> $past(|(irr & ~imr)));

    a_r6_oe_follows_inta: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> $past(!inta_n_i));

    a_r6_intr_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta_n_i && $past(inta_n_i)) |=> !intr_o);

    a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        base[ALIGN_W-1:0] == '0);

    a_r8_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && inta_n_i && (|isr)) |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

bind prio_intc prio_intc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .intr_o      (intr_o),
    .inta_n_i    (inta_n_i),
    .vec_oe_o    (vec_oe_o),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irr         (irr_w),
    .imr         (imr_w),
    .isr         (isr_w),
    .base        (base_w)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       intr;
    logic       inta_n = 1'b1;
    logic [7:0] vec;
    logic       vec_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .intr_o(intr), .inta_n_i(inta_n),
        .vec_o(vec), .vec_oe_o(vec_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: pushes the expected vector, then pulses the acknowledge
    task automatic ack(input logic [7:0] expv);
        @(negedge clk);
        exp_q.push_back(expv);
        inta_n = 1'b0;
        @(negedge clk);
        check("R6 intr low during ack", {7'b0, intr}, 8'h00);
        inta_n = 1'b1;
        @(negedge clk);
        check("R6 oe released", {7'b0, vec_oe}, 8'h00);
    endtask

    // Monitor: pops expectations whenever the vector is driven
    always @(negedge clk) begin
        if (vec_oe) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6: unexpected vector actual %02h expected none", vec);
            end else begin
                check("R6/R5 vector", vec, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        check("R1 intr", {7'b0, intr}, 8'h00);
        check("R1 oe", {7'b0, vec_oe}, 8'h00);
        bus_read(1'b1, r); check("R1 mask", r, 8'hFF);
        // R2 mask access
        bus_read(1'b0, r); check("R2 addr0 read", r, 8'h00);
        bus_write(1'b1, 8'h7E);
        bus_read(1'b1, r); check("R2 mask readback", r, 8'h7E);
        // R3 init: base 0x23 -> 0x20, then mask
        bus_write(1'b0, 8'h10);
        bus_write(1'b1, 8'h23);
        bus_read(1'b1, r); check("R3 mask kept during base load", r, 8'h7E);
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, r); check("R3 mask after base", r, 8'hFF);
        // R4 masked line
        irq = 8'h10;
        wait_cyc(3);
        check("R4 masked no intr", {7'b0, intr}, 8'h00);
        bus_write(1'b1, 8'hEF);
        wait_cyc(2);
        check("R4 unmasked intr", {7'b0, intr}, 8'h01);
        // R6 ack, vector base+4
        ack(8'h24);
        wait_cyc(2);
        check("R7 equal rank held", {7'b0, intr}, 8'h00);
        // R7 lower rank held, higher nests
        bus_write(1'b1, 8'h00);
        irq = 8'h50;
        wait_cyc(3);
        check("R7 lower rank held", {7'b0, intr}, 8'h00);
        irq = 8'h52;
        wait_cyc(3);
        check("R7 higher rank nests", {7'b0, intr}, 8'h01);
        ack(8'h21);
        irq = 8'h50;
        // R8 other command no effect
        bus_write(1'b0, 8'h05);
        wait_cyc(3);
        check("R8 non-EOI command ignored", {7'b0, intr}, 8'h00);
        // R8 EOI clears line 1 only; line 4 still in service
        bus_write(1'b0, 8'h20);
        wait_cyc(3);
        check("R8 first EOI keeps line 4", {7'b0, intr}, 8'h00);
        bus_write(1'b0, 8'h20);
        wait_cyc(3);
        check("R8 second EOI releases", {7'b0, intr}, 8'h01);
        // R5 priority among several
        irq = 8'hA8;
        wait_cyc(3);
        ack(8'h23);
        bus_write(1'b0, 8'h20);
        // R9 withdrawn request
        irq = 8'h00;
        wait_cyc(3);
        check("R9 withdrawn request", {7'b0, intr}, 8'h00);
        // R9 spurious ack
        ack(8'h27);
        irq = 8'h80;
        wait_cyc(3);
        check("R9 spurious leaves isr empty", {7'b0, intr}, 8'h01);
        ack(8'h27);
        wait_cyc(2);
        check("R6 queue drained", 8'(exp_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule